// File: doc/BRIEF.md
# Pager Receiver Mode Sequencer

This block decides when a paging receiver's radio front end is powered, so that the battery is drawn only around the slots that matter. It moves through four modes: switch-on, preamble, idle and lock. It counts bit periods, each marked by one strobe of an external bit clock. Pattern correlators elsewhere supply pulses for a preamble hit, a rate error, a sync-word hit and an address match, along with a level that stays high while a message is being received.

From these pulses and a static configuration, the block drives three duty-cycled front-end controls and a sync-valid flag, and it reports the current mode. The configuration holds the assigned frame, a lead time for the radio enable, a lead time for the synthesizer warm-up line, and a mode bit for the DC-restore line. A batch is one 32-bit sync slot followed by eight frames, each two code words (64 bits) long, for 544 bit periods in all. A position counter tracks the bit within the batch. Position 0 to 31 is the sync slot, and frame f spans positions 32+64f to 95+64f.

Top module: `pgr_mode_seq`

## Requirements
- R1: Reset puts the block in switch-on, with mode code 0 and every output low. A `cfg_load` pulse enters preamble mode. The mode codes are switch-on 0, preamble 1, idle 2 and lock 3.
- R2: Preamble mode counts 544 strobes and then falls to idle. A preamble hit restarts the count. Both `rf_en` and `pll_en` stay high for the whole of preamble mode. Any entry to idle puts the batch position at 32.
- R3: A rate-error pulse in preamble mode moves the block to idle on the next clock, unless a sync hit arrives in the same cycle.
- R4: A sync hit in preamble mode enters lock with the batch position at 32 (start of frame 0). Every accepted sync hit raises `sync_val` for the next 544 strobes.
- R5: In lock, `rf_en` and `pll_en` are high during the sync slot, during the slot of the configured frame, and within their lead before each of these slots. With frame 0 the two slots merge and the outputs stay high from the sync slot through frame 0. In lock, a sync hit during the sync slot realigns the position to 32.
- R6: Each lead is a 6-bit count of strobes before the slot start. Radio-enable codes above 59 act as 59, and warm-up codes above 61 act as 61. A lead that would reach before bit 0 of the batch starts at bit 0.
- R7: In lock, the end of a sync slot with no sync hit counts as a miss. A second consecutive miss moves the block to preamble if a preamble hit was seen during that slot, and to idle otherwise. No miss is counted while a message is held.
- R8: In idle, only the sync slot and its leads raise `rf_en` and `pll_en`. A preamble hit moves the block to preamble. During the first sync slot after a fall from lock, a sync hit returns the block to lock. At any other time a sync hit in idle is ignored.
- R9: With `dcr_mode`=0, `dcr_pulse` is high only in idle, during the radio-enable lead before the sync slot, and it stays low in lock. With `dcr_mode`=1, it is high during the sync slot in lock and idle and throughout preamble.
- R10: An address-match pulse in lock starts a message hold, which keeps `rf_en` and `pll_en` high until `msg_act` is low. A rising edge on `brk` ends the hold on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One pulse per received bit period |
| cfg_load | input | 1 | Configuration loaded; leave switch-on |
| pre_hit | input | 1 | Preamble pattern detected |
| rate_err | input | 1 | Rate-error threshold reached |
| sync_hit | input | 1 | Sync word detected |
| addr_hit | input | 1 | Own address matched |
| msg_act | input | 1 | Message words still arriving |
| brk | input | 1 | Break request, acted on at its rising edge |
| frame_sel | input | 3 | Assigned frame 0..7 |
| rf_lead | input | 6 | Radio-enable lead in strobes |
| pll_lead | input | 6 | Synthesizer warm-up lead in strobes |
| dcr_mode | input | 1 | DC-restore output behaviour select |
| rf_en | output | 1 | Radio front-end enable |
| dcr_pulse | output | 1 | DC-restore control |
| pll_en | output | 1 | Synthesizer warm-up control |
| sync_val | output | 1 | Sync-valid flag |
| mode | output | 2 | Current mode code |

## Verification
Mode, position, hold and counter changes land on the clock edge that samples the input pulse, so each consequence is visible exactly one cycle after the stimulus. The front-end outputs are decoded from that state and from the configuration without a further register, so a change of lead or frame takes effect in the same cycle. The bench advances its behavioural model on the same rising edge, drives stimulus one nanosecond after it, and compares all five outputs at the falling edge of every cycle. Each result is therefore checked in the cycle it becomes due.

// File: rtl/pgr_seq_pkg.sv
package pgr_seq_pkg;

    typedef enum logic [1:0] {
        MD_SWON = 2'd0,
        MD_PRE  = 2'd1,
        MD_IDLE = 2'd2,
        MD_LOCK = 2'd3
    } pgr_mode_e;

    // Replace an out-of-range lead code by the largest legal one.
    function automatic int lead_clamp(int code, int max_ok);
        return (code > max_ok) ? max_ok : code;
    endfunction

    // Sync slot at the start of the batch, plus its lead at the end of the previous batch.
    function automatic logic sync_span(int p, int lead, int batch, int slot);
        return (p < slot) || (p + lead >= batch);
    endfunction

    // Frame slot of length len starting at start, opened lead bits early.
    function automatic logic frame_span(int p, int lead, int start, int len);
        return (p + lead >= start) && (p < start + len);
    endfunction

endpackage

// File: rtl/pgr_mode_fsm.sv
module pgr_mode_fsm
    import pgr_seq_pkg::*;
#(
    parameter int SLOT   = 32,
    parameter int FRAMES = 8,
    parameter int WIN    = 544,
    localparam int BATCH = SLOT * (1 + 2 * FRAMES),
    localparam int PW    = $clog2(BATCH),
    localparam int WW    = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          cfg_load,
    input  logic          pre_hit,
    input  logic          rate_err,
    input  logic          sync_hit,
    input  logic          addr_hit,
    input  logic          msg_act,
    input  logic          brk,
    output pgr_mode_e     mode_o,
    output logic [PW-1:0] pos_o,
    output logic          msg_rx_o,
    output logic          sync_acc_o
);
    localparam logic [PW-1:0] SLOT_P     = PW'(SLOT);
    localparam logic [PW-1:0] SLOT_END   = PW'(SLOT - 1);
    localparam logic [PW-1:0] BATCH_LAST = PW'(BATCH - 1);
    localparam logic [WW-1:0] WIN_LAST   = WW'(WIN - 1);

    pgr_mode_e     mode_q;
    logic [PW-1:0] pos;
    logic [PW-1:0] pos_inc;
    logic [WW-1:0] pw;
    logic          miss, grace, pseen, msg_rx, brk_q;
    logic          in_sync, brk_rise;

    assign in_sync  = (pos < SLOT_P);
    assign brk_rise = brk && !brk_q;
    assign pos_inc  = (pos == BATCH_LAST) ? '0 : pos + 1'b1;

    assign sync_acc_o = sync_hit && ((mode_q == MD_PRE) ||
                        (in_sync && (mode_q == MD_LOCK || (mode_q == MD_IDLE && grace))));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_SWON;
            pos    <= '0;
            pw     <= '0;
            miss   <= 1'b0;
            grace  <= 1'b0;
            pseen  <= 1'b0;
            msg_rx <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            brk_q <= brk;
            if (brk_rise)                          msg_rx <= 1'b0;
            else if (mode_q == MD_LOCK && addr_hit) msg_rx <= 1'b1;
            else if (!msg_act)                     msg_rx <= 1'b0;

            case (mode_q)
                MD_SWON: begin
                    if (cfg_load) begin
                        mode_q <= MD_PRE;
                        pw     <= '0;
                    end
                end
                MD_PRE: begin
                    if (sync_hit) begin
                        mode_q <= MD_LOCK;
                        pos    <= SLOT_P;
                        miss   <= 1'b0;
                        pseen  <= 1'b0;
                    end else if (rate_err) begin
                        mode_q <= MD_IDLE;
                        pos    <= SLOT_P;
                        grace  <= 1'b0;
                    end else if (pre_hit) begin
                        pw <= '0;
                    end else if (bit_stb) begin
                        if (pw == WIN_LAST) begin
                            mode_q <= MD_IDLE;
                            pos    <= SLOT_P;
                            grace  <= 1'b0;
                        end else begin
                            pw <= pw + 1'b1;
                        end
                    end
                end
                MD_IDLE: begin
                    if (sync_hit && grace && in_sync) begin
                        mode_q <= MD_LOCK;
                        pos    <= SLOT_P;
                        miss   <= 1'b0;
                        pseen  <= 1'b0;
                        grace  <= 1'b0;
                    end else if (pre_hit) begin
                        mode_q <= MD_PRE;
                        pw     <= '0;
                        grace  <= 1'b0;
                    end else if (bit_stb) begin
                        pos <= pos_inc;
                        if (pos == SLOT_END) grace <= 1'b0;
                    end
                end
                default: begin
                    if (sync_hit && in_sync) begin
                        pos   <= SLOT_P;
                        miss  <= 1'b0;
                        pseen <= 1'b0;
                    end else begin
                        if (pre_hit && in_sync) pseen <= 1'b1;
                        if (bit_stb) begin
                            pos <= pos_inc;
                            if (pos == SLOT_END) begin
                                pseen <= 1'b0;
                                if (!msg_rx) begin
                                    if (!miss) begin
                                        miss <= 1'b1;
                                    end else begin
                                        miss <= 1'b0;
                                        if (pseen || pre_hit) begin
                                            mode_q <= MD_PRE;
                                            pw     <= '0;
                                        end else begin
                                            mode_q <= MD_IDLE;
                                            grace  <= 1'b1;
                                        end
                                    end
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign mode_o   = mode_q;
    assign pos_o    = pos;
    assign msg_rx_o = msg_rx;

    p_swon_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_SWON && !cfg_load) |=> (mode_q == MD_SWON));
    p_pre_rate_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_PRE && rate_err && !sync_hit) |=> (mode_q == MD_IDLE));
    p_pre_sync_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_PRE && sync_hit) |=> (mode_q == MD_LOCK && pos == SLOT_P));
    p_msg_stay_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_LOCK && msg_rx) |=> (mode_q == MD_LOCK));
    p_idle_pre_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_IDLE && pre_hit && !sync_acc_o) |=> (mode_q == MD_PRE));
    p_brk_clear_r10: assert property (@(posedge clk) disable iff (rst)
        brk_rise |=> !msg_rx);

endmodule

// File: rtl/pgr_sync_hold.sv
module pgr_sync_hold #(
    parameter int HOLD = 544,
    localparam int CW  = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic sync_acc,
    output logic sync_val
);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (sync_acc)               cnt <= HOLD_V;
        else if (bit_stb && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign sync_val = (cnt != '0);

    p_syncval_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_val) |-> $past(sync_acc));

endmodule

// File: rtl/pgr_rf_windows.sv
module pgr_rf_windows
    import pgr_seq_pkg::*;
#(
    parameter int SLOT    = 32,
    parameter int FRAMES  = 8,
    parameter int LEAD_W  = 6,
    parameter int RF_MAX  = 59,
    parameter int PLL_MAX = 61,
    localparam int BATCH  = SLOT * (1 + 2 * FRAMES),
    localparam int PW     = $clog2(BATCH),
    localparam int FW     = $clog2(FRAMES)
) (
    input  pgr_mode_e         mode,
    input  logic [PW-1:0]     pos,
    input  logic              msg_rx,
    input  logic [FW-1:0]     frame_sel,
    input  logic [LEAD_W-1:0] rf_lead,
    input  logic [LEAD_W-1:0] pll_lead,
    input  logic              dcr_mode,
    output logic              rf_en,
    output logic              pll_en,
    output logic              dcr_pulse
);
    int   p, rl, pl, fs;
    logic rf_sync, rf_frm, pl_sync, pl_frm, in_slot;

    always_comb begin
        p       = int'(pos);
        rl      = lead_clamp(int'(rf_lead), RF_MAX);
        pl      = lead_clamp(int'(pll_lead), PLL_MAX);
        fs      = SLOT + 2 * SLOT * int'(frame_sel);
        rf_sync = sync_span(p, rl, BATCH, SLOT);
        pl_sync = sync_span(p, pl, BATCH, SLOT);
        rf_frm  = frame_span(p, rl, fs, 2 * SLOT);
        pl_frm  = frame_span(p, pl, fs, 2 * SLOT);
        in_slot = (p < SLOT);

        rf_en     = 1'b0;
        pll_en    = 1'b0;
        dcr_pulse = 1'b0;
        case (mode)
            MD_PRE: begin
                rf_en     = 1'b1;
                pll_en    = 1'b1;
                dcr_pulse = dcr_mode;
            end
            MD_IDLE: begin
                rf_en     = rf_sync;
                pll_en    = pl_sync;
                dcr_pulse = dcr_mode ? in_slot : (p + rl >= BATCH);
            end
            MD_LOCK: begin
                rf_en     = rf_sync || rf_frm || msg_rx;
                pll_en    = pl_sync || pl_frm || msg_rx;
                dcr_pulse = dcr_mode && in_slot;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pgr_mode_seq.sv
module pgr_mode_seq
    import pgr_seq_pkg::*;
#(
    parameter int SLOT    = 32,
    parameter int FRAMES  = 8,
    parameter int WIN     = 544,
    parameter int HOLD    = 544,
    parameter int LEAD_W  = 6,
    parameter int RF_MAX  = 59,
    parameter int PLL_MAX = 61
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_stb,
    input  logic                        cfg_load,
    input  logic                        pre_hit,
    input  logic                        rate_err,
    input  logic                        sync_hit,
    input  logic                        addr_hit,
    input  logic                        msg_act,
    input  logic                        brk,
    input  logic [$clog2(FRAMES)-1:0]   frame_sel,
    input  logic [LEAD_W-1:0]           rf_lead,
    input  logic [LEAD_W-1:0]           pll_lead,
    input  logic                        dcr_mode,
    output logic                        rf_en,
    output logic                        dcr_pulse,
    output logic                        pll_en,
    output logic                        sync_val,
    output logic [1:0]                  mode
);
    localparam int BATCH = SLOT * (1 + 2 * FRAMES);
    localparam int PW    = $clog2(BATCH);

    pgr_mode_e     mode_w;
    logic [PW-1:0] pos_w;
    logic          msg_rx_w, sync_acc_w;

    pgr_mode_fsm #(.SLOT(SLOT), .FRAMES(FRAMES), .WIN(WIN)) u_fsm (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .cfg_load(cfg_load),
        .pre_hit(pre_hit), .rate_err(rate_err), .sync_hit(sync_hit),
        .addr_hit(addr_hit), .msg_act(msg_act), .brk(brk),
        .mode_o(mode_w), .pos_o(pos_w), .msg_rx_o(msg_rx_w), .sync_acc_o(sync_acc_w)
    );

    pgr_sync_hold #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .sync_acc(sync_acc_w), .sync_val(sync_val)
    );

    pgr_rf_windows #(
        .SLOT(SLOT), .FRAMES(FRAMES), .LEAD_W(LEAD_W), .RF_MAX(RF_MAX), .PLL_MAX(PLL_MAX)
    ) u_win (
        .mode(mode_w), .pos(pos_w), .msg_rx(msg_rx_w), .frame_sel(frame_sel),
        .rf_lead(rf_lead), .pll_lead(pll_lead), .dcr_mode(dcr_mode),
        .rf_en(rf_en), .pll_en(pll_en), .dcr_pulse(dcr_pulse)
    );

    assign mode = mode_w;

    p_pre_rf_on_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_w == MD_PRE) |-> (rf_en && pll_en));
    p_dcr_lock_low_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_w == MD_LOCK && !dcr_mode) |-> !dcr_pulse);

endmodule

// File: tb/tb_pgr_mode_seq.sv
`timescale 1ns/1ps
module tb_pgr_mode_seq;
    localparam int SLOT = 32, BATCH = 544, WIN = 544, HOLD = 544;

    logic clk = 1'b0;
    logic rst, bit_stb, cfg_load, pre_hit, rate_err, sync_hit, addr_hit, msg_act, brk, dcr_mode;
    logic [2:0] frame_sel;
    logic [5:0] rf_lead, pll_lead;
    logic rf_en, dcr_pulse, pll_en, sync_val;
    logic [1:0] mode;

    always #2.5 clk = ~clk;

    pgr_mode_seq dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .cfg_load(cfg_load), .pre_hit(pre_hit),
        .rate_err(rate_err), .sync_hit(sync_hit), .addr_hit(addr_hit), .msg_act(msg_act),
        .brk(brk), .frame_sel(frame_sel), .rf_lead(rf_lead), .pll_lead(pll_lead),
        .dcr_mode(dcr_mode), .rf_en(rf_en), .dcr_pulse(dcr_pulse), .pll_en(pll_en),
        .sync_val(sync_val), .mode(mode)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur = "R1";
    bit started = 0, gap_on = 0;

    // Behavioural reference: 0 switch-on, 1 preamble, 2 idle, 3 lock
    int m_mode, m_pos, m_win, m_miss, m_sv;
    bit m_grace, m_seen, m_msg, m_brk;

    task automatic model_step();
        bit rise, slot, slot_done, took;
        int nmode, npos, nwin, nmiss, nsv;
        bit ngrace, nseen, nmsg;
        rise = brk && !m_brk;
        slot = (m_pos < SLOT);
        slot_done = bit_stb && (m_pos == SLOT - 1);
        took = sync_hit && (m_mode == 1 || (slot && (m_mode == 3 || (m_mode == 2 && m_grace))));
        nmode = m_mode; npos = m_pos; nwin = m_win; nmiss = m_miss; nsv = m_sv;
        ngrace = m_grace; nseen = m_seen; nmsg = m_msg;
        if (took) nsv = HOLD; else if (bit_stb && m_sv > 0) nsv = m_sv - 1;
        if (rise) nmsg = 0; else if (m_mode == 3 && addr_hit) nmsg = 1; else if (!msg_act) nmsg = 0;
        if (m_mode == 0) begin
            if (cfg_load) begin nmode = 1; nwin = 0; end
        end else if (m_mode == 1) begin
            if (sync_hit) begin nmode = 3; npos = SLOT; nmiss = 0; nseen = 0; end
            else if (rate_err) begin nmode = 2; npos = SLOT; ngrace = 0; end
            else if (pre_hit) nwin = 0;
            else if (bit_stb) begin
                nwin = m_win + 1;
                if (nwin == WIN) begin nmode = 2; npos = SLOT; ngrace = 0; end
            end
        end else if (m_mode == 2) begin
            if (took) begin nmode = 3; npos = SLOT; nmiss = 0; nseen = 0; ngrace = 0; end
            else if (pre_hit) begin nmode = 1; nwin = 0; ngrace = 0; end
            else if (bit_stb) begin
                npos = (m_pos + 1) % BATCH;
                if (slot_done) ngrace = 0;
            end
        end else begin
            if (took) begin npos = SLOT; nmiss = 0; nseen = 0; end
            else begin
                if (pre_hit && slot) nseen = 1;
                if (bit_stb) npos = (m_pos + 1) % BATCH;
                if (slot_done) begin
                    nseen = 0;
                    if (!m_msg) begin
                        if (m_miss == 0) nmiss = 1;
                        else begin
                            nmiss = 0;
                            if (m_seen || pre_hit) begin nmode = 1; nwin = 0; end
                            else begin nmode = 2; ngrace = 1; end
                        end
                    end
                end
            end
        end
        m_mode = nmode; m_pos = npos; m_win = nwin; m_miss = nmiss; m_sv = nsv;
        m_grace = ngrace; m_seen = nseen; m_msg = nmsg; m_brk = brk;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_mode = 0; m_pos = 0; m_win = 0; m_miss = 0; m_sv = 0;
            m_grace = 0; m_seen = 0; m_msg = 0; m_brk = 0; started = 1;
        end else begin
            model_step();
        end
    end

    function automatic bit near(int lead, int start, int len);
        return (m_pos + lead >= start) && (m_pos < start + len);
    endfunction

    task automatic chk(string name, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", cur, name, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            int rl, pl, fst;
            bit e_rf, e_pll, e_dcr, s_r, s_p;
            rl = (rf_lead > 59) ? 59 : int'(rf_lead);
            pl = (pll_lead > 61) ? 61 : int'(pll_lead);
            fst = SLOT + 2 * SLOT * int'(frame_sel);
            s_r = (m_pos < SLOT) || (m_pos + rl >= BATCH);
            s_p = (m_pos < SLOT) || (m_pos + pl >= BATCH);
            e_rf = 0; e_pll = 0; e_dcr = 0;
            case (m_mode)
                1: begin e_rf = 1; e_pll = 1; e_dcr = dcr_mode; end
                2: begin e_rf = s_r; e_pll = s_p;
                         e_dcr = dcr_mode ? (m_pos < SLOT) : (m_pos + rl >= BATCH); end
                3: begin e_rf = s_r || near(rl, fst, 2 * SLOT) || m_msg;
                         e_pll = s_p || near(pl, fst, 2 * SLOT) || m_msg;
                         e_dcr = dcr_mode && (m_pos < SLOT); end
                default: ;
            endcase
            chk("mode", int'(mode), m_mode);
            chk("rf_en", int'(rf_en), int'(e_rf));
            chk("pll_en", int'(pll_en), int'(e_pll));
            chk("dcr_pulse", int'(dcr_pulse), int'(e_dcr));
            chk("sync_val", int'(sync_val), int'(m_sv > 0));
        end
    end

    initial begin
        bit_stb = 1'b1;
        forever begin
            @(posedge clk); #1;
            bit_stb = gap_on ? (cyc % 3 != 0) : 1'b1;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_pos(int p);
        for (int g = 0; g < 2000 && m_pos != p; g++) step(1);
    endtask

    task automatic wait_mode(int md);
        for (int g = 0; g < 3000 && m_mode != md; g++) step(1);
        chk("mode reached", m_mode, md);
    endtask

    task automatic pulse_sync();  sync_hit = 1; step(1); sync_hit = 0; endtask
    task automatic pulse_pre();   pre_hit  = 1; step(1); pre_hit  = 0; endtask

    initial begin
        rst = 1; cfg_load = 0; pre_hit = 0; rate_err = 0; sync_hit = 0; addr_hit = 0;
        msg_act = 0; brk = 0; dcr_mode = 0; frame_sel = 3'd3; rf_lead = 6'd10; pll_lead = 6'd20;
        cur = "R1"; step(3); rst = 0; step(6);
        cfg_load = 1; step(1); cfg_load = 0; step(20);
        cur = "R2"; step(300); pulse_pre(); step(400);
        chk("still preamble after restart", m_mode, 1);
        wait_mode(2);
        cur = "R8"; gap_on = 1; step(1200); gap_on = 0;
        wait_pos(5); pulse_sync(); step(10);            // no grace: ignored
        chk("sync outside grace ignored", int'(mode), 2);
        pulse_pre(); step(5);
        cur = "R3"; rate_err = 1; step(1); rate_err = 0; step(5);
        pulse_pre(); step(10);
        cur = "R4"; pulse_sync(); step(100);
        cur = "R5";
        for (int b = 0; b < 2; b++) begin wait_pos(4); pulse_sync(); end
        cur = "R10"; wait_pos(40); addr_hit = 1; msg_act = 1; step(1); addr_hit = 0;
        step(700); msg_act = 0; step(50);
        wait_pos(4); pulse_sync();
        addr_hit = 1; msg_act = 1; step(1); addr_hit = 0; step(100);
        brk = 1; step(3); brk = 0; step(50); msg_act = 0;
        cur = "R7"; wait_mode(2);
        cur = "R8"; wait_pos(6); pulse_sync(); step(20);
        chk("grace sync relocks", int'(mode), 3);
        cur = "R7"; wait_pos(10); step(50); wait_pos(10); pulse_pre(); wait_mode(1);
        cur = "R6"; rf_lead = 6'd63; pll_lead = 6'd62; frame_sel = 3'd1; step(5); pulse_sync();
        for (int b = 0; b < 2; b++) begin wait_pos(4); pulse_sync(); end
        cur = "R9"; dcr_mode = 1;
        for (int b = 0; b < 2; b++) begin wait_pos(4); pulse_sync(); end
        cur = "R5"; frame_sel = 3'd0; wait_pos(4); pulse_sync(); step(300);
        cur = "R9"; wait_mode(2); step(600);
        dcr_mode = 0; step(600);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule